// File: doc/BRIEF.md
# Debug Breakpoint Trigger Comparator

This block watches a processor's local bus and its fetch program counter and raises a breakpoint trigger when programmed conditions hold. Software loads a control word, a low and a high address bound, a data value with a data mask, and a PC value with a PC mask through a simple write port. On every cycle the block compares the bus address, the 32-bit bus data (qualified by access size and address alignment) and the fetch PC against these settings.

There are three address modes: exact match to the low bound, inclusive range, and strictly outside the range. They are combined with data comparators that cover a byte lane, a half of the bus or the whole longword. Every data comparator can have its sense inverted. The address and data results are ANDed into a bus condition. That condition is ORed with a masked PC region test, which can also be inverted. The result is registered into a one-cycle trigger pulse. A sticky status register records which causes fired, and software clears it by writing ones.

Top module: `bkpt_trigger`

## Requirements
- R1: After reset, trigger is 0, status is 0 and every programmable register is 0, so no condition is enabled.
- R2: A write with regWe high stores regWdata into the register chosen by regSel and takes effect from the next cycle: 0 control, 1 address low, 2 address high, 3 data value, 4 data mask, 5 PC value, 6 PC mask, 7 status (write one to clear).
- R3: With control bit 8 set, the address condition holds when busAddr equals the address low register.
- R4: With control bit 9 set, the address condition holds when low <= busAddr <= high; both bounds match.
- R5: With control bit 10 set, the address condition holds when busAddr < low or busAddr > high; the bounds themselves do not match.
- R6: Control bits 0..3 enable byte comparators for lanes 0..3 (lane k is busData[8k+7:8k]). Bit 4 enables the lower half (lanes 0,1), bit 5 the upper half (lanes 2,3) and bit 6 the full longword. A comparator matches when ((busData ^ dataValue) & dataMask) is zero over its lanes. It counts only when the access drives all of its lanes. busSize 0 is a byte access and drives lane busAddr[1:0]. busSize 1 is a half access and drives lanes 0,1 if busAddr[1] is 0, and lanes 2,3 otherwise. busSize 2 drives all lanes. busSize 3 drives none. The data condition is the OR of the enabled comparators that the access drives.
- R7: Control bit 7 inverts the result of every driven, enabled data comparator.
- R8: When both address and data enables are set, the bus condition is the AND of the two. When only one group is enabled, that group alone decides. When none of control bits 0..6 or 8..10 is set, there is no bus condition.
- R9: With control bit 11 set, a PC hit occurs on a valid cycle when ((fetchPc ^ pcValue) & pcMask) is zero. Control bit 12 inverts this test. A PC hit raises the trigger even when the bus condition fails.
- R10: trigger is high in exactly the cycle after a busValid cycle whose bus condition or PC hit holds; it is never raised for a cycle with busValid low.
- R11: status bit 0 (address), bit 1 (data) and bit 2 (PC) are set along with the trigger for each enabled cause that contributed. They stay set until a status write with a one in that bit, and a new hit in the same cycle as a clear keeps the bit set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| regWe | input | 1 | Register write strobe |
| regSel | input | 3 | Register select |
| regWdata | input | 32 | Register write data |
| busValid | input | 1 | Bus cycle valid |
| busAddr | input | ADDR_W (32) | Bus address |
| busData | input | 32 | Bus data |
| busSize | input | 2 | Access size: 0 byte, 1 half, 2 longword |
| fetchPc | input | PC_W (32) | Fetch program counter |
| trigger | output | 1 | Registered breakpoint trigger |
| status | output | 3 | Sticky cause bits: address, data, PC |

## Verification
The bench probes both range bounds and the addresses just beyond them in the inclusive and outside modes. An off-by-one compare would fire on a bound in the outside mode or miss it in the inclusive mode. It drives byte accesses at a lane other than the enabled one, and longword comparators with half accesses. A design that skipped lane qualification would fire on data that was never driven, and inversion would then turn undriven lanes into false hits. It also checks that a PC hit alone triggers while the address fails, that a clear coinciding with a new hit leaves the bit set, and that the trigger lasts one cycle only.

// File: rtl/bkpt_pkg.sv
package bkpt_pkg;
  localparam int DATA_W = 32;
  localparam int LANES = DATA_W / 8;
  localparam int CTRL_W = 13;
  localparam int STAT_W = 3;

  localparam logic [2:0] SEL_CTRL   = 3'd0;
  localparam logic [2:0] SEL_ALO    = 3'd1;
  localparam logic [2:0] SEL_AHI    = 3'd2;
  localparam logic [2:0] SEL_DVAL   = 3'd3;
  localparam logic [2:0] SEL_DMASK  = 3'd4;
  localparam logic [2:0] SEL_PCVAL  = 3'd5;
  localparam logic [2:0] SEL_PCMASK = 3'd6;
  localparam logic [2:0] SEL_STAT   = 3'd7;

  localparam int ST_ADDR = 0;
  localparam int ST_DATA = 1;
  localparam int ST_PC   = 2;

  // enable strobes from the control side to the comparators
  typedef struct packed {
    logic [LANES-1:0] byteEn;
    logic [1:0]       halfEn;
    logic             longEn;
    logic             dataInv;
    logic             addrExact;
    logic             addrIn;
    logic             addrOut;
    logic             pcEn;
    logic             pcInv;
  } cfg_t;

  // comparator results back to the control side
  typedef struct packed {
    logic addrCause;
    logic dataCause;
    logic busFire;
    logic pcFire;
  } hit_t;
endpackage

// File: rtl/bkpt_datapath.sv
module bkpt_datapath
  import bkpt_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int PC_W = 32
) (
  input  cfg_t              cfg,
  input  logic [ADDR_W-1:0] addrLo,
  input  logic [ADDR_W-1:0] addrHi,
  input  logic [DATA_W-1:0] dataVal,
  input  logic [DATA_W-1:0] dataMask,
  input  logic [PC_W-1:0]   pcVal,
  input  logic [PC_W-1:0]   pcMask,
  input  logic              busValid,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [DATA_W-1:0] busData,
  input  logic [1:0]        busSize,
  input  logic [PC_W-1:0]   fetchPc,
  output hit_t              hits
);
  localparam int HALVES = LANES / 2;

  logic [LANES-1:0]  laneDrv;
  logic [LANES-1:0]  laneEq;
  logic [LANES-1:0]  byteHit;
  logic [HALVES-1:0] halfHit;
  logic              longHit;
  logic              dataEnAny;
  logic              dataMatch;
  logic              addrEnAny;
  logic              addrMatch;
  logic              isExact;
  logic              isInside;
  logic              isOutside;
  logic              pcInRegion;

  // lanes actually driven by this access
  always_comb begin
    case (busSize)
      2'd0:    laneDrv = LANES'(1) << busAddr[1:0];
      2'd1:    laneDrv = busAddr[1] ? 4'b1100 : 4'b0011;
      2'd2:    laneDrv = '1;
      default: laneDrv = '0;
    endcase
  end

  genvar g;
  generate
    for (g = 0; g < LANES; g++) begin : gLane
      assign laneEq[g] = ((busData[8*g +: 8] ^ dataVal[8*g +: 8]) & dataMask[8*g +: 8]) == 8'd0;
      assign byteHit[g] = cfg.byteEn[g] & laneDrv[g] & (laneEq[g] ^ cfg.dataInv);
    end
    for (g = 0; g < HALVES; g++) begin : gHalf
      logic halfDrv;
      logic halfEq;
      assign halfDrv = laneDrv[2*g] & laneDrv[2*g+1];
      assign halfEq = laneEq[2*g] & laneEq[2*g+1];
      assign halfHit[g] = cfg.halfEn[g] & halfDrv & (halfEq ^ cfg.dataInv);
    end
  endgenerate

  assign longHit = cfg.longEn & (&laneDrv) & ((&laneEq) ^ cfg.dataInv);
  assign dataEnAny = (|cfg.byteEn) | (|cfg.halfEn) | cfg.longEn;
  assign dataMatch = (|byteHit) | (|halfHit) | longHit;

  // address compares
  assign isExact = busAddr == addrLo;
  assign isInside = (busAddr >= addrLo) && (busAddr <= addrHi);
  assign isOutside = (busAddr < addrLo) || (busAddr > addrHi);
  assign addrEnAny = cfg.addrExact | cfg.addrIn | cfg.addrOut;
  assign addrMatch = (cfg.addrExact & isExact) | (cfg.addrIn & isInside) | (cfg.addrOut & isOutside);

  // masked PC region
  assign pcInRegion = ((fetchPc ^ pcVal) & pcMask) == '0;

  always_comb begin
    hits.busFire = busValid & (addrEnAny | dataEnAny)
                 & (~addrEnAny | addrMatch) & (~dataEnAny | dataMatch);
    hits.addrCause = hits.busFire & addrEnAny;
    hits.dataCause = hits.busFire & dataEnAny;
    hits.pcFire = busValid & cfg.pcEn & (pcInRegion ^ cfg.pcInv);
  end
endmodule

// File: rtl/bkpt_ctrl.sv
module bkpt_ctrl
  import bkpt_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int PC_W = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              regWe,
  input  logic [2:0]        regSel,
  input  logic [31:0]       regWdata,
  input  hit_t              hits,
  output cfg_t              cfg,
  output logic [ADDR_W-1:0] addrLo,
  output logic [ADDR_W-1:0] addrHi,
  output logic [DATA_W-1:0] dataVal,
  output logic [DATA_W-1:0] dataMask,
  output logic [PC_W-1:0]   pcVal,
  output logic [PC_W-1:0]   pcMask,
  output logic              trigger,
  output logic [STAT_W-1:0] status
);
  logic [CTRL_W-1:0] ctrlQ;
  logic [STAT_W-1:0] statSet;
  logic [STAT_W-1:0] statClr;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ctrlQ    <= '0;
      addrLo   <= '0;
      addrHi   <= '0;
      dataVal  <= '0;
      dataMask <= '0;
      pcVal    <= '0;
      pcMask   <= '0;
    end else if (regWe) begin
      case (regSel)
        SEL_CTRL:   ctrlQ    <= regWdata[CTRL_W-1:0];
        SEL_ALO:    addrLo   <= regWdata[ADDR_W-1:0];
        SEL_AHI:    addrHi   <= regWdata[ADDR_W-1:0];
        SEL_DVAL:   dataVal  <= regWdata[DATA_W-1:0];
        SEL_DMASK:  dataMask <= regWdata[DATA_W-1:0];
        SEL_PCVAL:  pcVal    <= regWdata[PC_W-1:0];
        SEL_PCMASK: pcMask   <= regWdata[PC_W-1:0];
        default:    ;
      endcase
    end
  end

  // control word fields
  assign cfg.byteEn    = ctrlQ[3:0];
  assign cfg.halfEn    = ctrlQ[5:4];
  assign cfg.longEn    = ctrlQ[6];
  assign cfg.dataInv   = ctrlQ[7];
  assign cfg.addrExact = ctrlQ[8];
  assign cfg.addrIn    = ctrlQ[9];
  assign cfg.addrOut   = ctrlQ[10];
  assign cfg.pcEn      = ctrlQ[11];
  assign cfg.pcInv     = ctrlQ[12];

  always_comb begin
    statSet = '0;
    statSet[ST_ADDR] = hits.addrCause;
    statSet[ST_DATA] = hits.dataCause;
    statSet[ST_PC]   = hits.pcFire;
    statClr = (regWe && regSel == SEL_STAT) ? regWdata[STAT_W-1:0] : '0;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      trigger <= 1'b0;
      status  <= '0;
    end else begin
      trigger <= hits.busFire | hits.pcFire;
      status  <= (status & ~statClr) | statSet;
    end
  end
endmodule

// File: rtl/bkpt_trigger.sv
module bkpt_trigger
  import bkpt_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int PC_W = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              regWe,
  input  logic [2:0]        regSel,
  input  logic [31:0]       regWdata,
  input  logic              busValid,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [31:0]       busData,
  input  logic [1:0]        busSize,
  input  logic [PC_W-1:0]   fetchPc,
  output logic              trigger,
  output logic [2:0]        status
);
  cfg_t              cfg;
  hit_t              hits;
  logic [ADDR_W-1:0] addrLo;
  logic [ADDR_W-1:0] addrHi;
  logic [DATA_W-1:0] dataVal;
  logic [DATA_W-1:0] dataMask;
  logic [PC_W-1:0]   pcVal;
  logic [PC_W-1:0]   pcMask;

  bkpt_ctrl #(.ADDR_W(ADDR_W), .PC_W(PC_W)) ctrl_i (
    .clk(clk), .rstN(rstN), .regWe(regWe), .regSel(regSel), .regWdata(regWdata),
    .hits(hits), .cfg(cfg), .addrLo(addrLo), .addrHi(addrHi), .dataVal(dataVal),
    .dataMask(dataMask), .pcVal(pcVal), .pcMask(pcMask), .trigger(trigger), .status(status)
  );

  bkpt_datapath #(.ADDR_W(ADDR_W), .PC_W(PC_W)) dp_i (
    .cfg(cfg), .addrLo(addrLo), .addrHi(addrHi), .dataVal(dataVal), .dataMask(dataMask),
    .pcVal(pcVal), .pcMask(pcMask), .busValid(busValid), .busAddr(busAddr),
    .busData(busData), .busSize(busSize), .fetchPc(fetchPc), .hits(hits)
  );
endmodule

// File: rtl/bkpt_trigger_chk.sv
module bkpt_trigger_chk
  import bkpt_pkg::*;
#(
  parameter int ADDR_W = 32
) (
  input logic              clk,
  input logic              rstN,
  input logic              regWe,
  input logic [2:0]        regSel,
  input logic [31:0]       regWdata,
  input logic              busValid,
  input logic [ADDR_W-1:0] busAddr,
  input logic              trigger,
  input logic [2:0]        status,
  input cfg_t              cfg,
  input logic [ADDR_W-1:0] addrLo
);
  logic noBusEn;
  logic dataOff;
  assign noBusEn = (cfg.byteEn == '0) && (cfg.halfEn == '0) && !cfg.longEn
                && !cfg.addrExact && !cfg.addrIn && !cfg.addrOut;
  assign dataOff = (cfg.byteEn == '0) && (cfg.halfEn == '0) && !cfg.longEn;

  AST_TRIG_NEEDS_VALID: assert property (@(posedge clk) disable iff (!rstN)
    trigger |-> $past(busValid)); // R10

  AST_TRIG_HAS_CAUSE: assert property (@(posedge clk) disable iff (!rstN)
    trigger |-> (status != 3'b000)); // R11

  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rstN)
    (noBusEn && !cfg.pcEn) |=> !trigger); // R8

  AST_EXACT_FIRES: assert property (@(posedge clk) disable iff (!rstN)
    (busValid && cfg.addrExact && dataOff && busAddr == addrLo) |=> trigger); // R3

  genvar i;
  generate
    for (i = 0; i < 3; i++) begin : gSticky
      AST_STATUS_STICKY: assert property (@(posedge clk) disable iff (!rstN)
        (status[i] && !(regWe && regSel == SEL_STAT && regWdata[i])) |=> status[i]); // R11
    end
  endgenerate
endmodule

bind bkpt_trigger bkpt_trigger_chk #(.ADDR_W(ADDR_W)) chk_i (
  .clk(clk), .rstN(rstN), .regWe(regWe), .regSel(regSel), .regWdata(regWdata),
  .busValid(busValid), .busAddr(busAddr), .trigger(trigger), .status(status),
  .cfg(cfg), .addrLo(addrLo)
);

// File: tb/bkpt_trigger_tb_top.sv
module bkpt_trigger_tb_top;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        regWe = 1'b0;
  logic [2:0]  regSel = '0;
  logic [31:0] regWdata = '0;
  logic        busValid = 1'b0;
  logic [31:0] busAddr = '0;
  logic [31:0] busData = '0;
  logic [1:0]  busSize = '0;
  logic [31:0] fetchPc = '0;
  logic        trigger;
  logic [2:0]  status;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  bkpt_trigger dut_i (
    .clk(clk), .rstN(rstN), .regWe(regWe), .regSel(regSel), .regWdata(regWdata),
    .busValid(busValid), .busAddr(busAddr), .busData(busData), .busSize(busSize),
    .fetchPc(fetchPc), .trigger(trigger), .status(status)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] sel, input logic [31:0] val);
    @(negedge clk);
    regWe = 1'b1; regSel = sel; regWdata = val;
    @(negedge clk);
    regWe = 1'b0;
  endtask

  // one valid cycle, then sample the registered trigger
  task automatic cyc(input string tag, input logic [31:0] a, input logic [31:0] d,
                     input logic [1:0] sz, input logic [31:0] pc, input logic exp);
    @(negedge clk);
    busValid = 1'b1; busAddr = a; busData = d; busSize = sz; fetchPc = pc;
    @(negedge clk);
    busValid = 1'b0;
    check(tag, {31'd0, trigger}, {31'd0, exp});
  endtask

  task automatic setup(input logic [31:0] ctrl);
    wr(3'd0, ctrl);
    wr(3'd7, 32'h7);
  endtask

  task automatic tReset;
    check("R1 trigger after reset", {31'd0, trigger}, 32'd0);
    check("R1 status after reset", {29'd0, status}, 32'd0);
    cyc("R1 nothing enabled", 32'h0, 32'h0, 2'd2, 32'h0, 1'b0);
  endtask

  task automatic tExact;
    wr(3'd1, 32'h1000);
    setup(32'h100);
    cyc("R3 exact hit", 32'h1000, 32'h0, 2'd2, 32'h0, 1'b1);
    check("R11 address cause", {29'd0, status}, 32'h1);
    cyc("R3 exact miss", 32'h1004, 32'h0, 2'd2, 32'h0, 1'b0);
    wr(3'd1, 32'h1004);
    cyc("R2 new low bound used", 32'h1004, 32'h0, 2'd2, 32'h0, 1'b1);
  endtask

  task automatic tRange;
    wr(3'd1, 32'h100); wr(3'd2, 32'h200);
    setup(32'h200);
    cyc("R4 low bound", 32'h100, 0, 2'd2, 0, 1'b1);
    cyc("R4 high bound", 32'h200, 0, 2'd2, 0, 1'b1);
    cyc("R4 above", 32'h201, 0, 2'd2, 0, 1'b0);
    cyc("R4 below", 32'hFF, 0, 2'd2, 0, 1'b0);
    setup(32'h400);
    cyc("R5 low bound", 32'h100, 0, 2'd2, 0, 1'b0);
    cyc("R5 high bound", 32'h200, 0, 2'd2, 0, 1'b0);
    cyc("R5 below", 32'hFF, 0, 2'd2, 0, 1'b1);
    cyc("R5 above", 32'h201, 0, 2'd2, 0, 1'b1);
  endtask

  task automatic tData;
    wr(3'd4, 32'hFFFF_FFFF);
    wr(3'd3, 32'h0000_00AB);
    setup(32'h001);
    cyc("R6 lane0 byte hit", 32'h0, 32'h0000_00AB, 2'd0, 0, 1'b1);
    check("R11 data cause", {29'd0, status}, 32'h2);
    cyc("R6 lane0 undriven", 32'h3, 32'h0000_00AB, 2'd0, 0, 1'b0);
    cyc("R6 lane0 via half", 32'h0, 32'h0000_00AB, 2'd1, 0, 1'b1);
    wr(3'd3, 32'hCD00_0000);
    setup(32'h008);
    cyc("R6 lane3 byte hit", 32'h3, 32'hCD00_0000, 2'd0, 0, 1'b1);
    cyc("R6 lane3 byte at lane0", 32'h0, 32'hCD00_0000, 2'd0, 0, 1'b0);
    wr(3'd3, 32'h1234_5678);
    setup(32'h020);
    cyc("R6 upper half hit", 32'h2, 32'h1234_0000, 2'd1, 0, 1'b1);
    cyc("R6 upper half at low", 32'h0, 32'h1234_0000, 2'd1, 0, 1'b0);
    setup(32'h040);
    cyc("R6 long hit", 32'h0, 32'h1234_5678, 2'd2, 0, 1'b1);
    cyc("R6 long under half", 32'h0, 32'h1234_5678, 2'd1, 0, 1'b0);
    wr(3'd4, 32'h0000_00F0);
    cyc("R6 masked bits ignored", 32'h0, 32'h1234_5679, 2'd2, 0, 1'b1);
    cyc("R6 masked bits compared", 32'h0, 32'h1234_5688, 2'd2, 0, 1'b0);
  endtask

  task automatic tInvert;
    wr(3'd4, 32'hFFFF_FFFF);
    wr(3'd3, 32'h0000_00AB);
    setup(32'h081);
    cyc("R7 inverted mismatch", 32'h0, 32'h0000_00AC, 2'd0, 0, 1'b1);
    cyc("R7 inverted match", 32'h0, 32'h0000_00AB, 2'd0, 0, 1'b0);
    cyc("R7 inverted undriven", 32'h1, 32'h0000_00AC, 2'd0, 0, 1'b0);
  endtask

  task automatic tCombine;
    wr(3'd1, 32'h40);
    wr(3'd3, 32'h55);
    setup(32'h140);
    cyc("R8 address only", 32'h40, 32'h56, 2'd2, 0, 1'b0);
    cyc("R8 data only", 32'h44, 32'h55, 2'd2, 0, 1'b0);
    cyc("R8 both", 32'h40, 32'h55, 2'd2, 0, 1'b1);
    check("R11 both causes", {29'd0, status}, 32'h3);
    setup(32'h0);
    cyc("R8 all disabled", 32'h40, 32'h55, 2'd2, 0, 1'b0);
  endtask

  task automatic tPc;
    wr(3'd5, 32'h0000_8000);
    wr(3'd6, 32'hFFFF_F000);
    wr(3'd1, 32'h10);
    setup(32'h800);
    cyc("R9 pc in region", 0, 0, 2'd2, 32'h0000_8ABC, 1'b1);
    check("R11 pc cause", {29'd0, status}, 32'h4);
    cyc("R9 pc outside", 0, 0, 2'd2, 32'h0000_9000, 1'b0);
    setup(32'h1800);
    cyc("R9 inverted outside", 0, 0, 2'd2, 32'h0000_9000, 1'b1);
    cyc("R9 inverted inside", 0, 0, 2'd2, 32'h0000_8ABC, 1'b0);
    setup(32'h900);
    cyc("R9 pc overrides address miss", 32'h20, 0, 2'd2, 32'h0000_8001, 1'b1);
  endtask

  task automatic tLatency;
    wr(3'd1, 32'h1000);
    setup(32'h100);
    @(negedge clk);
    busValid = 1'b0; busAddr = 32'h1000; busSize = 2'd2;
    @(negedge clk);
    check("R10 no trigger without valid", {31'd0, trigger}, 32'd0);
    cyc("R10 trigger after valid", 32'h1000, 0, 2'd2, 0, 1'b1);
    @(negedge clk);
    check("R10 single cycle pulse", {31'd0, trigger}, 32'd0);
  endtask

  task automatic tStatus;
    wr(3'd5, 32'h0);
    wr(3'd6, 32'h0);
    wr(3'd1, 32'h80);
    setup(32'h900);
    cyc("R11 two causes fire", 32'h80, 0, 2'd2, 0, 1'b1);
    check("R11 address and pc set", {29'd0, status}, 32'h5);
    wr(3'd7, 32'h1);
    check("R11 clear one bit only", {29'd0, status}, 32'h4);
    @(negedge clk);
    check("R11 sticky while idle", {29'd0, status}, 32'h4);
    @(negedge clk);
    busValid = 1'b1; busAddr = 32'h80;
    regWe = 1'b1; regSel = 3'd7; regWdata = 32'h5;
    @(negedge clk);
    busValid = 1'b0; regWe = 1'b0;
    check("R11 set wins over clear", {29'd0, status}, 32'h5);
    wr(3'd7, 32'h7);
    check("R11 full clear", {29'd0, status}, 32'h0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    tReset();
    tExact();
    tRange();
    tData();
    tInvert();
    tCombine();
    tPc();
    tLatency();
    tStatus();
    if (!done) begin
      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule